// File: doc/BRIEF.md
# Multi-rate line receive datapath selector

This block sits between the line-side receive pins and four downstream overhead-processing lanes, numbered 0 to 3. A 5-bit rate mode sets how the incoming data is shaped. In aggregate mode a 16-bit parallel input is packed, two words at a time, into a 32-bit word. This halves the word rate, and the result feeds all four lanes at once. In either of the two quad modes, each lane has its own serial input, and each run of eight bits is collected into a byte for that lane alone. A loopback control can replace the line data with terminal loopback data.

Each line clock is modelled as a per-input sample strobe, and all inputs are sampled on the rising edge of one core clock. The divide-by-two and divide-by-eight ratios are therefore counts of accepted strobes. The mode and the loopback control are watched for changes. Any change restarts all packing, so the first output after a change is always a whole word or byte.

Top module: `lrx_line_rx`

## Requirements
- R1: The mode encodings are: 5'b10000 selects aggregate, and 5'b01111 and 5'b00000 both select quad. Any other value drives mode_err high in the same cycle and holds out_valid at 4'b0000. A legal value keeps mode_err low.
- R2: In aggregate mode, every second accepted word (agg_vld high at a rising edge) completes an output. The first word of the pair goes to out_data[31:16] and the second to out_data[15:0]. out_valid is 4'b1111 for the one cycle after the edge that sampled the second word.
- R3: In aggregate mode, out_valid is always either 4'b0000 or 4'b1111. Words accepted at odd positions in the count produce no output.
- R4: In quad mode, lane i shifts in ser_bit[i] on every edge where ser_en[i] is high. After eight accepted bits, the byte appears on out_data[8i+7:8i], with the first bit in bit 7. out_valid[i] is high for the one cycle after the edge that sampled the eighth bit.
- R5: In quad mode the four lanes count on their own. A strobe on one lane does not change the bit count or the output of any other lane.
- R6: When lpbk is 1 and the mode is legal, lb_data and lb_vld sampled at an edge appear on out_data and out_valid for the following cycle. The line inputs are ignored.
- R7: In a cycle where mode or lpbk differs from its value in the previous cycle, all strobes are discarded and all packing counts restart at zero. After reset, the previous values are taken as mode 5'b00000 and lpbk 0.
- R8: After synchronous reset (rst high at an edge), out_data is all zero and out_valid is 4'b0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 5 | Rate mode setting |
| lpbk | input | 1 | Terminal loopback select |
| agg_data | input | 16 | Aggregate-mode parallel word |
| agg_vld | input | 1 | Aggregate word sample strobe |
| ser_bit | input | 4 | Serial data, one bit per lane |
| ser_en | input | 4 | Serial bit sample strobe per lane |
| lb_data | input | 32 | Terminal loopback word |
| lb_vld | input | 4 | Terminal loopback per-lane valid |
| out_data | output | 32 | Lane data; lane i on bits 8i+7:8i |
| out_valid | output | 4 | Per-lane output strobe |
| mode_err | output | 1 | Illegal mode indicator |

## Verification
mode_err follows the present mode with no delay. Packed words, deserialized bytes and loopback words are all registered once, so each is due in the cycle that follows the edge which sampled its last input. The bench applies inputs on the falling edge and advances its reference model at the rising edge, using the inputs that were held across that edge. It then compares outputs at the next falling edge, which is exactly the one-cycle delay. Mode and loopback changes in the middle of a word show whether the discard-and-restart rule lands on the cycle of the change.

// File: rtl/lrx_pkg.sv
package lrx_pkg;
    parameter int MODE_W = 5;
    parameter int AGG_W  = 16;
    parameter int LANES  = 4;
    parameter int BYTE_W = 8;
    localparam int WORD_W = 2 * AGG_W;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef enum logic [MODE_W-1:0] {
        RATE_AGG = 5'b10000,
        RATE_Q12 = 5'b01111,
        RATE_Q3  = 5'b00000
    } rate_e;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_AGG,
        SRC_QUAD,
        SRC_LOOP
    } src_e;

    typedef struct packed {
        logic              vld;
        logic [BYTE_W-1:0] data;
    } lane_out_t;

    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] data;
    } word_out_t;

    function automatic logic rate_legal(input logic [MODE_W-1:0] m);
        return (m == RATE_AGG) || (m == RATE_Q12) || (m == RATE_Q3);
    endfunction

    function automatic src_e pick_src(input logic [MODE_W-1:0] m, input logic lb);
        if (!rate_legal(m))  return SRC_NONE;
        if (lb)              return SRC_LOOP;
        if (m == RATE_AGG)   return SRC_AGG;
        return SRC_QUAD;
    endfunction
endpackage

// File: rtl/lrx_word_packer.sv
module lrx_word_packer
    import lrx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic [AGG_W-1:0] in_word,
    input  logic             in_vld,
    output word_out_t        pk_out
);
    logic             phase_q;
    logic [AGG_W-1:0] hold_q;
    word_out_t        out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= 1'b0;
            hold_q   <= '0;
            out_q    <= '0;
        end else if (clr) begin
            phase_q   <= 1'b0;
            out_q.vld <= 1'b0;
        end else begin
            out_q.vld <= 1'b0;
            if (en && in_vld) begin
                if (!phase_q) begin
                    hold_q  <= in_word;
                    phase_q <= 1'b1;
                end else begin
                    out_q.data <= {hold_q, in_word};
                    out_q.vld  <= 1'b1;
                    phase_q    <= 1'b0;
                end
            end
        end
    end

    assign pk_out = out_q;

    // R2: a packed word only follows a held first half
    a_r2_pair_before_out: assert property (@(posedge clk) disable iff (rst)
        out_q.vld |-> $past(phase_q));

    // R7: a change cycle leaves the packer at the start of a word
    a_r7_clear_phase: assert property (@(posedge clk) disable iff (rst)
        clr |=> !phase_q && !out_q.vld);
endmodule

// File: rtl/lrx_bit_deser.sv
module lrx_bit_deser
    import lrx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clr,
    input  logic      en,
    input  logic      bit_in,
    input  logic      bit_en,
    output lane_out_t ds_out
);
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] sh_q;
    logic [BYTE_W-1:0] sh_next;
    lane_out_t         out_q;

    assign sh_next = {sh_q[BYTE_W-2:0], bit_in};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            sh_q  <= '0;
            out_q <= '0;
        end else if (clr) begin
            cnt_q     <= '0;
            out_q.vld <= 1'b0;
        end else begin
            out_q.vld <= 1'b0;
            if (en && bit_en) begin
                sh_q <= sh_next;
                if (cnt_q == CNT_W'(BYTE_W - 1)) begin
                    out_q.data <= sh_next;
                    out_q.vld  <= 1'b1;
                    cnt_q      <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign ds_out = out_q;

    // R4: a byte is released only on the last bit of the count
    a_r4_full_byte: assert property (@(posedge clk) disable iff (rst)
        out_q.vld |-> $past(cnt_q) == CNT_W'(BYTE_W - 1));
endmodule

// File: rtl/lrx_out_mux.sv
module lrx_out_mux
    import lrx_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  src_e                    src,
    input  word_out_t               agg_in,
    input  lane_out_t [LANES-1:0]   lane_in,
    input  logic [WORD_W-1:0]       lb_data,
    input  logic [LANES-1:0]        lb_vld,
    output logic [WORD_W-1:0]       out_data,
    output logic [LANES-1:0]        out_valid
);
    logic [WORD_W-1:0] lb_data_q;
    logic [LANES-1:0]  lb_vld_q;
    logic [WORD_W-1:0] quad_data;
    logic [LANES-1:0]  quad_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            lb_data_q <= '0;
            lb_vld_q  <= '0;
        end else if (src == SRC_LOOP && !clr) begin
            lb_data_q <= lb_data;
            lb_vld_q  <= lb_vld;
        end else begin
            lb_vld_q  <= '0;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign quad_data[g*BYTE_W +: BYTE_W] = lane_in[g].data;
        assign quad_vld[g]                   = lane_in[g].vld;
    end

    always_comb begin
        unique case (src)
            SRC_LOOP: begin
                out_data  = lb_data_q;
                out_valid = lb_vld_q;
            end
            SRC_AGG: begin
                out_data  = agg_in.data;
                out_valid = {LANES{agg_in.vld}};
            end
            SRC_QUAD: begin
                out_data  = quad_data;
                out_valid = quad_vld;
            end
            default: begin
                out_data  = quad_data;
                out_valid = '0;
            end
        endcase
    end
endmodule

// File: rtl/lrx_line_rx.sv
module lrx_line_rx
    import lrx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [MODE_W-1:0]     mode,
    input  logic                  lpbk,
    input  logic [AGG_W-1:0]      agg_data,
    input  logic                  agg_vld,
    input  logic [LANES-1:0]      ser_bit,
    input  logic [LANES-1:0]      ser_en,
    input  logic [WORD_W-1:0]     lb_data,
    input  logic [LANES-1:0]      lb_vld,
    output logic [WORD_W-1:0]     out_data,
    output logic [LANES-1:0]      out_valid,
    output logic                  mode_err
);
    logic [MODE_W-1:0]    mode_q;
    logic                 lpbk_q;
    logic                 chg;
    src_e                 src;
    word_out_t            agg_out;
    lane_out_t [LANES-1:0] lane_out;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= RATE_Q3;
            lpbk_q <= 1'b0;
        end else begin
            mode_q <= mode;
            lpbk_q <= lpbk;
        end
    end

    assign chg      = (mode != mode_q) || (lpbk != lpbk_q);
    assign src      = pick_src(mode, lpbk);
    assign mode_err = !rate_legal(mode);

    lrx_word_packer u_pack (
        .clk     (clk),
        .rst     (rst),
        .clr     (chg),
        .en      (src == SRC_AGG),
        .in_word (agg_data),
        .in_vld  (agg_vld),
        .pk_out  (agg_out)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_deser
        lrx_bit_deser u_deser (
            .clk    (clk),
            .rst    (rst),
            .clr    (chg),
            .en     (src == SRC_QUAD),
            .bit_in (ser_bit[g]),
            .bit_en (ser_en[g]),
            .ds_out (lane_out[g])
        );
    end

    lrx_out_mux u_mux (
        .clk       (clk),
        .rst       (rst),
        .clr       (chg),
        .src       (src),
        .agg_in    (agg_out),
        .lane_in   (lane_out),
        .lb_data   (lb_data),
        .lb_vld    (lb_vld),
        .out_data  (out_data),
        .out_valid (out_valid)
    );

    // R1: an illegal mode never lets a strobe out
    a_r1_err_quiet: assert property (@(posedge clk) disable iff (rst)
        mode_err |-> out_valid == '0);

    // R3: aggregate output strobes all lanes together or none
    a_r3_all_lanes: assert property (@(posedge clk) disable iff (rst)
        (mode == RATE_AGG && !lpbk) |-> (out_valid == '0 || out_valid == '1));

    // R8: outputs are quiet right after reset
    a_r8_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> out_valid == '0);
endmodule

// File: tb/lrx_line_rx_test.sv
`timescale 1ns/1ps
module lrx_line_rx_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  mode;
    logic        lpbk;
    logic [15:0] agg_data;
    logic        agg_vld;
    logic [3:0]  ser_bit;
    logic [3:0]  ser_en;
    logic [31:0] lb_data;
    logic [3:0]  lb_vld;
    logic [31:0] out_data;
    logic [3:0]  out_valid;
    logic        mode_err;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // reference state
    logic [4:0]  pm;
    logic        pl;
    logic        ph;
    logic [15:0] hold;
    logic [31:0] ad;
    logic        av;
    logic [2:0]  cnt [4];
    logic [7:0]  sh  [4];
    logic [7:0]  qd  [4];
    logic [3:0]  qv;
    logic [31:0] ld;
    logic [3:0]  lv;

    always #2 clk = ~clk;

    lrx_line_rx uut (
        .clk(clk), .rst(rst), .mode(mode), .lpbk(lpbk),
        .agg_data(agg_data), .agg_vld(agg_vld),
        .ser_bit(ser_bit), .ser_en(ser_en),
        .lb_data(lb_data), .lb_vld(lb_vld),
        .out_data(out_data), .out_valid(out_valid), .mode_err(mode_err)
    );

    function automatic bit legal(input logic [4:0] m);
        return m == 5'b10000 || m == 5'b01111 || m == 5'b00000;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic mdl_reset();
        pm = 5'b00000; pl = 1'b0; ph = 1'b0; hold = '0; ad = '0; av = 1'b0;
        qv = '0; ld = '0; lv = '0;
        for (int i = 0; i < 4; i++) begin cnt[i] = '0; sh[i] = '0; qd[i] = '0; end
    endtask

    task automatic mdl_edge();
        bit c, lg, ae, qe, le;
        lg = legal(mode);
        c  = (mode != pm) || (lpbk != pl);
        pm = mode; pl = lpbk;
        ae = lg && !lpbk && mode == 5'b10000;
        qe = lg && !lpbk && mode != 5'b10000;
        le = lg && lpbk;
        av = 1'b0;
        if (c) ph = 1'b0;
        else if (ae && agg_vld) begin
            if (!ph) begin hold = agg_data; ph = 1'b1; end
            else begin ad = {hold, agg_data}; av = 1'b1; ph = 1'b0; end
        end
        for (int i = 0; i < 4; i++) begin
            qv[i] = 1'b0;
            if (c) cnt[i] = '0;
            else if (qe && ser_en[i]) begin
                sh[i] = {sh[i][6:0], ser_bit[i]};
                if (cnt[i] == 3'd7) begin qd[i] = sh[i]; qv[i] = 1'b1; cnt[i] = '0; end
                else cnt[i] = cnt[i] + 3'd1;
            end
        end
        if (le && !c) begin ld = lb_data; lv = lb_vld; end
        else lv = '0;
    endtask

    task automatic compare(input string tag);
        logic [31:0] ed;
        logic [3:0]  ev;
        bit lg;
        lg = legal(mode);
        chk({tag, " R1 err"}, {31'd0, mode_err}, {31'd0, !lg});
        if (!lg) begin ev = '0; ed = '0; end
        else if (lpbk) begin ev = lv; ed = ld; end
        else if (mode == 5'b10000) begin ev = av ? 4'hF : 4'h0; ed = ad; end
        else begin ev = qv; ed = {qd[3], qd[2], qd[1], qd[0]}; end
        chk({tag, " valid"}, {28'd0, out_valid}, {28'd0, ev});
        for (int i = 0; i < 4; i++)
            if (ev[i]) chk({tag, " data"}, {24'd0, out_data[8*i +: 8]}, {24'd0, ed[8*i +: 8]});
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        mdl_edge();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle();
        agg_vld = 1'b0; ser_en = '0; lb_vld = '0;
    endtask

    task automatic send_byte(input int lane, input logic [7:0] b);
        for (int k = 7; k >= 0; k--) begin
            idle();
            ser_en[lane] = 1'b1;
            ser_bit[lane] = b[k];
            step("R4 byte");
        end
        idle();
    endtask

    initial begin
        #400000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; mode = 5'b10000; lpbk = 1'b0;
        agg_data = '0; ser_bit = '0; lb_data = '0;
        idle();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        mdl_reset();
        chk("R8 reset data", out_data, 32'd0);
        chk("R8 reset valid", {28'd0, out_valid}, 32'd0);

        // first cycle is a change from the reset value: strobe discarded (R7)
        agg_vld = 1'b1; agg_data = 16'hDEAD;
        step("R7 first after reset");
        agg_data = 16'h1234; step("R2 first half");
        chk("R3 no output on first half", {28'd0, out_valid}, 32'd0);
        agg_data = 16'hABCD; step("R2 second half");
        chk("R2 packed word", out_data, 32'h1234ABCD);
        chk("R2 all lanes", {28'd0, out_valid}, 32'hF);
        idle(); step("R2 pulse");
        chk("R2 single pulse", {28'd0, out_valid}, 32'd0);

        for (int n = 0; n < 300; n++) begin
            agg_vld = 1'($urandom); agg_data = 16'($urandom);
            ser_en = 4'($urandom); ser_bit = 4'($urandom);
            step("R3 random aggregate");
        end

        // mid-word mode change to quad
        agg_vld = 1'b1; agg_data = 16'h5555; step("R7 half word");
        mode = 5'b01111; step("R7 change cycle");
        idle();
        send_byte(2, 8'hA5);
        chk("R4 lane2 byte", {24'd0, out_data[23:16]}, 32'hA5);
        chk("R5 only lane2", {28'd0, out_valid}, 32'h4);

        for (int n = 0; n < 600; n++) begin
            ser_en = 4'($urandom); ser_bit = 4'($urandom);
            agg_vld = 1'($urandom); agg_data = 16'($urandom);
            step("R5 random quad");
        end

        mode = 5'b00000; idle(); step("R7 quad change");
        send_byte(0, 8'h3C);
        chk("R4 lane0 byte", {24'd0, out_data[7:0]}, 32'h3C);
        for (int n = 0; n < 400; n++) begin
            ser_en = 4'($urandom); ser_bit = 4'($urandom);
            step("R4 random quad3");
        end

        // illegal modes
        mode = 5'b00101;
        for (int n = 0; n < 60; n++) begin
            ser_en = 4'($urandom); agg_vld = 1'($urandom); lb_vld = 4'($urandom);
            lpbk = 1'(n / 30);
            step("R1 illegal");
        end
        lpbk = 1'b0;
        mode = 5'b10001; step("R1 illegal near agg");

        // loopback
        mode = 5'b10000; lpbk = 1'b1; idle(); step("R7 loop change");
        lb_data = 32'hCAFEF00D; lb_vld = 4'hF; agg_vld = 1'b1;
        step("R6 loop word");
        chk("R6 loop data", out_data, 32'hCAFEF00D);
        for (int n = 0; n < 300; n++) begin
            lb_data = $urandom; lb_vld = 4'($urandom);
            agg_vld = 1'($urandom); ser_en = 4'($urandom);
            if (n == 150) mode = 5'b01111;
            step("R6 random loop");
        end

        // leave loopback in the middle of line traffic
        lpbk = 1'b0; mode = 5'b10000; idle();
        agg_vld = 1'b1; agg_data = 16'h0F0F; step("R7 leave loop");
        agg_data = 16'h1111; step("R2 after loop a");
        agg_data = 16'h2222; step("R2 after loop b");
        chk("R2 word after loop", out_data, 32'h11112222);
        for (int n = 0; n < 300; n++) begin
            agg_vld = 1'($urandom); agg_data = 16'($urandom);
            if (n % 97 == 50) lpbk = ~lpbk;
            step("R7 random toggles");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule